// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that lives on a 32-bit memory-mapped register bus. Software programs a timeout in units of 512 slow-clock ticks and a set of behaviour bits. It then has to keep writing a restart command before the count runs out. If the count runs out, the block raises an interrupt, drives a reset pulse of programmable polarity, or does both in sequence. Software can also ask for an immediate reset pulse.

Every write carries a key, and each register checks a different field for it. Any write whose key or command value is wrong is dropped without trace. A single stray store therefore cannot reconfigure, feed or fire the watchdog. The slow clock arrives as a one-cycle enable, `tick_i`, in the system clock domain. Three registers can be read back: the behaviour bits, the programmed length and the units that remain in the current count.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the interrupt is low, the reset output sits at its inactive level (high, because the polarity bit resets to 0), the behaviour bits read 0, the length reads 64 units (0x0000_0800 at offset 0x04) and the remaining count reads 64.
- R2: A write to offset 0x00 is taken only when bits 31:24 equal 0x22. It loads enable (bit 0), polarity (bit 1, 1 = reset active high), reset enable (bit 2), interrupt enable (bit 3), auto start (bit 4) and dual mode (bit 6). Reading offset 0x00 returns those bits in the same places and 0 in all other bits. A write with any other key leaves them unchanged.
- R3: A write to offset 0x04 is taken only when bits 4:0 equal 0x08. It loads the unit count from bits 15:5. Reading offset 0x04 returns that count in bits 15:5 and zero elsewhere. A write with any other key leaves the length unchanged.
- R4: Writing exactly 0x0000_1971 to offset 0x08 reloads the count from the length, restarts the unit prescaler, clears the interrupt and clears the dual-mode stage. Any other value written there has no effect. Reading offset 0x08 returns the remaining units.
- R5: While enabled, the count drops by one every 512 ticks. An expiry happens exactly max(L,1)×512 ticks after a reload with length L, and the count then reloads from the length.
- R6: While enable is 0, the count and the prescaler hold their values and no expiry happens.
- R7: When an expiry happens with dual mode off, the interrupt goes high if interrupt enable is set and stays high until a restart. If reset enable is set, the reset output is active for exactly 8 cycles.
- R8: With dual mode on, the first expiry raises the interrupt whatever the interrupt enable says and produces no reset pulse. A second expiry with no restart in between produces the 8-cycle pulse if reset enable is set.
- R9: The reset output is active high when the polarity bit is 1 and active low when it is 0.
- R10: Writing exactly 0x0000_1209 to offset 0x14 starts the 8-cycle reset pulse on the next edge, whatever the enable and reset-enable bits are. Any other value written there has no effect.
- R11: With auto start set, an accepted length write also reloads the count with the new length. With auto start clear, the running count keeps its value.
- R12: A restart that lands on the same edge as the tick ending the last unit takes priority. No expiry action happens, and the count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at the slow-clock rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data, including the key |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Timeout interrupt, level |
| wdt_rst_o | output | 1 | Reset pulse at the programmed polarity |

## Verification
A restart write and the tick that ends the last unit can meet on the same clock edge. In that case the feed must win outright. The bench counts edges from a restart and issues the next restart so that it lands exactly on the expiring edge. It then expects the interrupt to stay low, the reset output to stay inactive and the count to read back as the full length. The edge just before and the edge of expiry are also sampled separately in the timing checks, so a one-cycle shift of either path shows up as a failure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned OFS_MODE  = 32'h00;
    localparam int unsigned OFS_LEN   = 32'h04;
    localparam int unsigned OFS_KICK  = 32'h08;
    localparam int unsigned OFS_SWRST = 32'h14;

    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_VAL  = 32'h0000_1971;
    localparam logic [31:0] SWRST_VAL = 32'h0000_1209;
    localparam int unsigned LEN_LSB   = 5;

    typedef struct packed {
        logic dual;
        logic auto_go;
        logic irq_en;
        logic rst_en;
        logic pol_high;
        logic en;
    } mode_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned LEN_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LEN_W-1:0]  cnt,
    output mode_t             mode,
    output logic [LEN_W-1:0]  len,
    output logic              kick,
    output logic              swrst,
    output logic              reload,
    output logic [LEN_W-1:0]  reload_val,
    output logic [31:0]       rd_data
);

    typedef struct packed {
        mode_t             mode;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  hit_mode, hit_len;
    logic [LEN_W-1:0] new_len;

    always_comb begin
        hit_mode = wr_en && (wr_addr == ADDR_W'(OFS_MODE)) && (wr_data[31:24] == MODE_KEY);
        hit_len  = wr_en && (wr_addr == ADDR_W'(OFS_LEN)) && (wr_data[4:0] == LEN_KEY);
        kick     = wr_en && (wr_addr == ADDR_W'(OFS_KICK)) && (wr_data == KICK_VAL);
        swrst    = wr_en && (wr_addr == ADDR_W'(OFS_SWRST)) && (wr_data == SWRST_VAL);
        new_len  = wr_data[LEN_LSB +: LEN_W];

        nxt_d = cur_q;
        if (hit_mode) begin
            nxt_d.mode.en       = wr_data[0];
            nxt_d.mode.pol_high = wr_data[1];
            nxt_d.mode.rst_en   = wr_data[2];
            nxt_d.mode.irq_en   = wr_data[3];
            nxt_d.mode.auto_go  = wr_data[4];
            nxt_d.mode.dual     = wr_data[6];
        end
        if (hit_len) begin
            nxt_d.len = new_len;
        end

        reload     = kick || (hit_len && cur_q.mode.auto_go);
        reload_val = hit_len ? new_len : cur_q.len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= '0;
            cur_q.len  <= LEN_W'(LEN_RST);
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        mode = cur_q.mode;
        len  = cur_q.len;
        if (rd_addr == ADDR_W'(OFS_MODE)) begin
            rd_data = {25'd0, cur_q.mode.dual, 1'b0, cur_q.mode.auto_go,
                       cur_q.mode.irq_en, cur_q.mode.rst_en,
                       cur_q.mode.pol_high, cur_q.mode.en};
        end else if (rd_addr == ADDR_W'(OFS_LEN)) begin
            rd_data = 32'(cur_q.len) << LEN_LSB;
        end else if (rd_addr == ADDR_W'(OFS_KICK)) begin
            rd_data = 32'(cnt);
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int unsigned LEN_W      = 11,
    parameter int unsigned LEN_RST    = 64,
    parameter int unsigned UNIT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             reload,
    input  logic [LEN_W-1:0] reload_val,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             expire
);

    localparam int unsigned PRE_W = (UNIT_TICKS > 2) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;
    logic unit_done;

    always_comb begin
        unit_done = en && tick && (cur_q.pre == PRE_LAST);
        expire    = unit_done && (cur_q.cnt <= LEN_W'(1)) && !reload;

        nxt_d = cur_q;
        if (reload) begin
            nxt_d.cnt = reload_val;
            nxt_d.pre = '0;
        end else if (en && tick) begin
            if (unit_done) begin
                nxt_d.pre = '0;
                nxt_d.cnt = (cur_q.cnt <= LEN_W'(1)) ? len : cur_q.cnt - LEN_W'(1);
            end else begin
                nxt_d.pre = cur_q.pre + PRE_W'(1);
            end
        end
        cnt = cur_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pre <= '0;
            cur_q.cnt <= LEN_W'(LEN_RST);
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp #(
    parameter int unsigned RST_PULSE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dual,
    input  logic irq_en,
    input  logic rst_en,
    input  logic pol_high,
    input  logic expire,
    input  logic kick,
    input  logic swrst,
    output logic irq,
    output logic pulse_on,
    output logic rst_out
);

    localparam int unsigned PC_W = $clog2(RST_PULSE + 1);

    typedef struct packed {
        logic            irq;
        logic            stage;
        logic [PC_W-1:0] pcnt;
    } resp_t;

    resp_t cur_q, nxt_d;
    logic  fire;

    always_comb begin
        nxt_d = cur_q;
        fire  = 1'b0;
        if (kick) begin
            nxt_d.irq   = 1'b0;
            nxt_d.stage = 1'b0;
        end
        if (expire) begin
            if (dual) begin
                if (!cur_q.stage) begin
                    nxt_d.irq   = 1'b1;
                    nxt_d.stage = 1'b1;
                end else begin
                    nxt_d.stage = 1'b0;
                    fire        = rst_en;
                end
            end else begin
                nxt_d.irq = cur_q.irq || irq_en;
                fire      = rst_en;
            end
        end
        if (swrst) begin
            fire = 1'b1;
        end
        if (fire) begin
            nxt_d.pcnt = PC_W'(RST_PULSE);
        end else if (cur_q.pcnt != '0) begin
            nxt_d.pcnt = cur_q.pcnt - PC_W'(1);
        end

        irq      = cur_q.irq;
        pulse_on = (cur_q.pcnt != '0);
        rst_out  = pol_high ? pulse_on : !pulse_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned LEN_W      = 11,
    parameter int unsigned LEN_RST    = 64,
    parameter int unsigned UNIT_TICKS = 512,
    parameter int unsigned RST_PULSE  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    mode_t            mode;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] reload_val;
    logic             kick, swrst, reload, expire, pulse_on;

    wdt_regs #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .LEN_RST (LEN_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en_i),
        .wr_addr    (wr_addr_i),
        .wr_data    (wr_data_i),
        .rd_addr    (rd_addr_i),
        .cnt        (cnt),
        .mode       (mode),
        .len        (len),
        .kick       (kick),
        .swrst      (swrst),
        .reload     (reload),
        .reload_val (reload_val),
        .rd_data    (rd_data_o)
    );

    wdt_count #(
        .LEN_W      (LEN_W),
        .LEN_RST    (LEN_RST),
        .UNIT_TICKS (UNIT_TICKS)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mode.en),
        .tick       (tick_i),
        .reload     (reload),
        .reload_val (reload_val),
        .len        (len),
        .cnt        (cnt),
        .expire     (expire)
    );

    wdt_resp #(
        .RST_PULSE (RST_PULSE)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual     (mode.dual),
        .irq_en   (mode.irq_en),
        .rst_en   (mode.rst_en),
        .pol_high (mode.pol_high),
        .expire   (expire),
        .kick     (kick),
        .swrst    (swrst),
        .irq      (irq_o),
        .pulse_on (pulse_on),
        .rst_out  (wdt_rst_o)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [31:0]       wr_data_i,
    input logic              irq_o,
    input mode_t             mode,
    input logic [LEN_W-1:0]  cnt,
    input logic              reload,
    input logic              kick,
    input logic              swrst,
    input logic              expire,
    input logic              pulse_on
);

    // R2
    mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == ADDR_W'(OFS_MODE) && wr_data_i[31:24] == MODE_KEY)
        |=> $stable(mode));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.en && !reload) |=> $stable(cnt));

    // R4
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !irq_o);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire));

    // R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> $past(expire || swrst));

endmodule

bind wdt_keyed wdt_keyed_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .mode      (mode),
    .cnt       (cnt),
    .reload    (reload),
    .kick      (kick),
    .swrst     (swrst),
    .expire    (expire),
    .pulse_on  (pulse_on)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;

    localparam int UNIT = 512;
    localparam int PULSE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        wrst;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .wdt_rst_o (wrst)
    );

    function automatic logic [31:0] mode_word(input logic [6:0] bits);
        return 32'h2200_0000 | 32'(bits);
    endfunction

    function automatic logic [31:0] len_word(input int units);
        return (32'(units) << 5) | 32'h08;
    endfunction

    function automatic logic exp_irq(input logic [6:0] m);
        return m[6] | m[3];
    endfunction

    function automatic logic exp_rst(input logic [6:0] m);
        logic act;
        act = !m[6] && m[2];
        return m[1] ? act : !act;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        edges(1);

        // R1 reset state
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        check(wrst == 1'b1, "R1 rst level", 32'(wrst), 1);
        rd(8'h00, v); check(v == 0, "R1 mode", v, 0);
        rd(8'h04, v); check(v == 32'h800, "R1 length", v, 32'h800);
        rd(8'h08, v); check(v == 64, "R1 count", v, 64);

        // R2 wrong key ignored, right key taken
        wr(8'h00, 32'h2300_005F);
        rd(8'h00, v); check(v == 0, "R2 bad key", v, 0);
        wr(8'h00, mode_word(7'h4E));
        rd(8'h00, v); check(v == 32'h4E, "R2 good key", v, 32'h4E);
        wr(8'h00, mode_word(7'h09));
        rd(8'h00, v); check(v == 32'h09, "R2 rewrite", v, 32'h09);

        // R3 length key
        wr(8'h04, (32'd5 << 5) | 32'h09);
        rd(8'h04, v); check(v == 32'h800, "R3 bad key", v, 32'h800);
        wr(8'h04, len_word(2));
        rd(8'h04, v); check(v == 32'h40, "R3 good key", v, 32'h40);

        // R4 restart value
        wr(8'h08, 32'h1971);
        edges(600);
        rd(8'h08, v); check(v == 1, "R4 count ran", v, 1);
        wr(8'h08, 32'h1970);
        rd(8'h08, v); check(v == 1, "R4 wrong value", v, 1);
        wr(8'h08, 32'h1971);
        rd(8'h08, v); check(v == 2, "R4 reload", v, 2);

        // R5 / R7 expiry timing, irq only
        wr(8'h08, 32'h1971);
        edges(2 * UNIT - 1);
        check(irq == 1'b0, "R5 before expiry", 32'(irq), 0);
        edges(1);
        check(irq == 1'b1, "R5 at expiry", 32'(irq), 1);
        rd(8'h08, v); check(v == 2, "R5 count reloaded", v, 2);
        check(wrst == 1'b1, "R7 no pulse without rst_en", 32'(wrst), 1);
        wr(8'h08, 32'h1971);
        check(irq == 1'b0, "R4 irq cleared", 32'(irq), 0);

        // R7 / R9 pulse, active high
        wr(8'h00, mode_word(7'h07));
        wr(8'h04, len_word(1));
        wr(8'h08, 32'h1971);
        edges(UNIT);
        check(wrst == 1'b1, "R9 high active", 32'(wrst), 1);
        check(irq == 1'b0, "R7 irq off", 32'(irq), 0);
        edges(PULSE - 1);
        check(wrst == 1'b1, "R7 pulse last cycle", 32'(wrst), 1);
        edges(1);
        check(wrst == 1'b0, "R7 pulse ended", 32'(wrst), 0);

        // R9 active low
        wr(8'h00, mode_word(7'h05));
        wr(8'h08, 32'h1971);
        edges(UNIT);
        check(wrst == 1'b0, "R9 low active", 32'(wrst), 0);
        edges(PULSE);
        check(wrst == 1'b1, "R9 low released", 32'(wrst), 1);

        // R6 freeze
        wr(8'h04, len_word(2));
        wr(8'h00, mode_word(7'h09));
        wr(8'h08, 32'h1971);
        edges(600);
        wr(8'h00, mode_word(7'h08));
        edges(2000);
        rd(8'h08, v); check(v == 1, "R6 count frozen", v, 1);
        check(irq == 1'b0, "R6 no expiry", 32'(irq), 0);

        // R8 dual mode
        wr(8'h00, mode_word(7'h47));
        wr(8'h04, len_word(1));
        wr(8'h08, 32'h1971);
        edges(UNIT);
        check(irq == 1'b1, "R8 first irq", 32'(irq), 1);
        check(wrst == 1'b0, "R8 no first reset", 32'(wrst), 0);
        edges(UNIT);
        check(wrst == 1'b1, "R8 second reset", 32'(wrst), 1);
        edges(PULSE);
        wr(8'h08, 32'h1971);

        // R10 software reset
        wr(8'h00, mode_word(7'h02));
        wr(8'h14, 32'h1208);
        check(wrst == 1'b0, "R10 wrong value", 32'(wrst), 0);
        wr(8'h14, 32'h1209);
        check(wrst == 1'b1, "R10 pulse", 32'(wrst), 1);
        edges(PULSE);
        check(wrst == 1'b0, "R10 pulse end", 32'(wrst), 0);

        // R11 auto start
        wr(8'h00, mode_word(7'h01));
        wr(8'h04, len_word(3));
        wr(8'h08, 32'h1971);
        edges(600);
        wr(8'h04, len_word(1));
        rd(8'h08, v); check(v == 2, "R11 no reload", v, 2);
        wr(8'h00, mode_word(7'h11));
        wr(8'h04, len_word(3));
        rd(8'h08, v); check(v == 3, "R11 auto reload", v, 3);

        // R12 restart on the expiring edge
        wr(8'h00, mode_word(7'h0D));
        wr(8'h04, len_word(1));
        wr(8'h08, 32'h1971);
        edges(UNIT - 1);
        wr(8'h08, 32'h1971);
        check(irq == 1'b0, "R12 irq held off", 32'(irq), 0);
        check(wrst == 1'b1, "R12 no pulse", 32'(wrst), 1);
        rd(8'h08, v); check(v == 1, "R12 count reloaded", v, 1);

        // R7 R8 R9 randomized modes
        for (int i = 0; i < 8; i++) begin
            logic [6:0] m;
            int l;
            m = 7'($urandom) & 7'h4E;
            m[0] = 1'b1;
            l = 1 + int'($urandom % 2);
            wr(8'h00, mode_word(m));
            wr(8'h04, len_word(l));
            wr(8'h08, 32'h1971);
            edges(l * UNIT);
            check(irq == exp_irq(m), "R7 random irq", 32'(irq), 32'(exp_irq(m)));
            check(wrst == exp_rst(m), "R9 random rst", 32'(wrst), 32'(exp_rst(m)));
            edges(PULSE + 2);
            wr(8'h08, 32'h1971);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule